// File: doc/BRIEF.md
# Branch-Predictor Sleep Mode Controller

This block selects a low-power operating mode for the peripheral circuitry of a branch predictor. It watches a strobe that pulses once for each fetched branch and counts these pulses over windows of a fixed number of cycles. A window that closes with too few branches means the code is running long stretches between branches. The predictor is then lightly used, so the block declares a high instructions-per-branch (IPB) phase. That phase is predicted to last a fixed number of further windows.

Two pipeline indications push the predictor into deeper sleep. A pre-stall flag warns that a stall is coming, and a stall flag marks the stall itself. The block merges these flags with the phase prediction into one two-bit mode. The mode drives the predictor's sleep circuitry, which sits outside this block. A status bit reports whether a high-IPB phase is in force.

Top module: `bps_sleep_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its cycle, branch and hold counters. After that edge `mode` reads 2'b00 and `high_ipb` reads 0.
- R2: Windows are WINDOW_CYCLES (default 512) clock edges long. The first window starts at the first edge after reset is released. The branch count restarts at every window boundary, so branches from one window never count toward the next.
- R3: A window that closes with fewer than BR_THRESH (default 24) strobes sets `high_ipb` at that window's last edge. A window that closes with exactly BR_THRESH strobes does not set it.
- R4: Once set, `high_ipb` stays 1 through the next HOLD_WINDOWS (default 20) windows. It clears at the last edge of the HOLD_WINDOWS-th following window, unless that window is itself under the threshold.
- R5: If a window closes under the threshold while a hold is running, the hold restarts at HOLD_WINDOWS full windows.
- R6: `mode` is registered. It is set at each edge from the flags and `high_ipb` as they stood just before that edge. The encodings are 2'b00 basic, 2'b01 light (high IPB), 2'b10 aggressive (pre-stall) and 2'b11 ultra (stall).
- R7: With `pre_stall` high and `stall` low, the next `mode` is 2'b10, whatever `high_ipb` is.
- R8: With `stall` high, the next `mode` is 2'b11, whatever `pre_stall` and `high_ipb` are.
- R9: The branch count saturates and cannot wrap. A window with a strobe on every cycle never sets `high_ipb`.
- R10: With no flag raised and `high_ipb` low, the next `mode` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_fetch | input | 1 | One pulse per fetched branch, at most one per cycle |
| pre_stall | input | 1 | A stall is expected soon |
| stall | input | 1 | The pipeline is stalled |
| mode | output | 2 | Registered sleep mode (00 basic, 01 light, 10 aggressive, 11 ultra) |
| high_ipb | output | 1 | A high-IPB phase is being held |

## Verification
The checker tests the mode priority on every cycle: stall over pre-stall, pre-stall over the phase bit, and the phase bit over basic. It also checks on every cycle that the hold counter is reloaded to its full value after each under-threshold window, that it never exceeds that value, that the phase bit rises only at a window boundary, and that the branch count stays within its saturation limit. Other behaviours only show up at the ports, across whole windows, so they come from the bench's scenarios. These are:
- window alignment after reset;
- the off-by-one boundary at exactly the threshold;
- the count restarting between windows;
- the exact window in which a hold expires;
- a reload that extends a hold;
- a saturated window.

// File: rtl/bps_pkg.sv
// Package: shared mode encoding for the branch-predictor sleep controller.
// Assumes: a two-bit mode bus read by the sleep circuitry outside the block.
package bps_pkg;

    typedef enum logic [1:0] {
        MODE_BASIC = 2'b00,
        MODE_LIGHT = 2'b01,
        MODE_AGGR  = 2'b10,
        MODE_ULTRA = 2'b11
    } bps_mode_e;

endpackage

// File: rtl/bps_window_ctr.sv
// Module: bps_window_ctr
// Splits time into windows of WINDOW_CYCLES edges. It counts branch strobes
// within each window, saturating at BR_THRESH, and flags a window that closes
// under the threshold.
// Assumes: at most one strobe per cycle; synchronous active-low reset.
module bps_window_ctr #(
    parameter int WINDOW_CYCLES = 512,
    parameter int BR_THRESH     = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic br_fetch,
    output logic win_end,
    output logic win_under,
    output logic [$clog2(BR_THRESH+1)-1:0] br_cnt
);

    localparam int CW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam int BW = $clog2(BR_THRESH + 1);
    localparam logic [CW-1:0] LAST_CYC = CW'(WINDOW_CYCLES - 1);
    localparam logic [BW-1:0] THR      = BW'(BR_THRESH);

    logic [CW-1:0] cyc_cnt;
    logic [BW-1:0] br_next;

    // Purpose: count including this cycle's strobe, held at the threshold.
    always_comb begin
        if (br_cnt == THR) begin
            br_next = THR;
        end else begin
            br_next = br_cnt + BW'(br_fetch);
        end
    end

    assign win_end   = (cyc_cnt == LAST_CYC);
    assign win_under = win_end && (br_next < THR);

    // Purpose: advance the cycle position inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_cnt <= '0;
        end else if (win_end) begin
            cyc_cnt <= '0;
        end else begin
            cyc_cnt <= cyc_cnt + CW'(1);
        end
    end

    // Purpose: accumulate branches and restart the count at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_cnt <= '0;
        end else if (win_end) begin
            br_cnt <= '0;
        end else begin
            br_cnt <= br_next;
        end
    end

endmodule

// File: rtl/bps_hold_ctr.sv
// Module: bps_hold_ctr
// Holds a high-IPB prediction for HOLD_WINDOWS windows after each window that
// closes under the threshold. A new under-threshold window reloads the count.
// Assumes: win_under is only ever high together with win_end.
module bps_hold_ctr #(
    parameter int HOLD_WINDOWS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_end,
    input  logic win_under,
    output logic [$clog2(HOLD_WINDOWS+1)-1:0] hold_cnt,
    output logic high_ipb
);

    localparam int HW = $clog2(HOLD_WINDOWS + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_WINDOWS);

    // Purpose: load on an under-threshold window, else count windows down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (win_under) begin
            hold_cnt <= HOLD_LOAD;
        end else if (win_end && (hold_cnt != '0)) begin
            hold_cnt <= hold_cnt - HW'(1);
        end
    end

    assign high_ipb = (hold_cnt != '0);

endmodule

// File: rtl/bps_mode_sel.sv
// Module: bps_mode_sel
// Registers the sleep mode from the stall flags and the phase bit, in fixed
// priority order: stall, then pre-stall, then high IPB, then basic.
// Assumes: the flags come from synchronous pipeline logic.
module bps_mode_sel
    import bps_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stall,
    input  logic      pre_stall,
    input  logic      high_ipb,
    output bps_mode_e mode_q
);

    bps_mode_e mode_d;

    // Purpose: choose the deepest mode that any active condition asks for.
    always_comb begin
        if (stall) begin
            mode_d = MODE_ULTRA;
        end else if (pre_stall) begin
            mode_d = MODE_AGGR;
        end else if (high_ipb) begin
            mode_d = MODE_LIGHT;
        end else begin
            mode_d = MODE_BASIC;
        end
    end

    // Purpose: update the mode only on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_BASIC;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/bps_sleep_ctrl.sv
// Module: bps_sleep_ctrl (top)
// Picks the sleep mode for the branch predictor's peripheral circuits. The
// choice comes from a windowed high-IPB phase predictor and the stall flags.
// Assumes: at most one branch strobe per cycle; synchronous active-low reset.
module bps_sleep_ctrl #(
    parameter int WINDOW_CYCLES = 512,
    parameter int BR_THRESH     = 24,
    parameter int HOLD_WINDOWS  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       br_fetch,
    input  logic       pre_stall,
    input  logic       stall,
    output logic [1:0] mode,
    output logic       high_ipb
);

    import bps_pkg::*;

    localparam int BW = $clog2(BR_THRESH + 1);
    localparam int HW = $clog2(HOLD_WINDOWS + 1);

    logic          win_end;
    logic          win_under;
    logic [BW-1:0] br_cnt;
    logic [HW-1:0] hold_cnt;
    bps_mode_e     mode_q;

    bps_window_ctr #(
        .WINDOW_CYCLES (WINDOW_CYCLES),
        .BR_THRESH     (BR_THRESH)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_fetch  (br_fetch),
        .win_end   (win_end),
        .win_under (win_under),
        .br_cnt    (br_cnt)
    );

    bps_hold_ctr #(
        .HOLD_WINDOWS (HOLD_WINDOWS)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end   (win_end),
        .win_under (win_under),
        .hold_cnt  (hold_cnt),
        .high_ipb  (high_ipb)
    );

    bps_mode_sel u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .pre_stall (pre_stall),
        .high_ipb  (high_ipb),
        .mode_q    (mode_q)
    );

    assign mode = mode_q;

endmodule

// File: rtl/bps_sleep_chk.sv
// Module: bps_sleep_chk
// Checker for bps_sleep_ctrl, attached to it by the bind statement at the end
// of this file. It watches the ports and the signals passed between the
// window counter, the hold counter and the mode selector.
module bps_sleep_chk #(
    parameter int BR_THRESH    = 24,
    parameter int HOLD_WINDOWS = 20
) (
    input logic clk,
    input logic rst_n,
    input logic pre_stall,
    input logic stall,
    input logic [1:0] mode,
    input logic high_ipb,
    input logic win_end,
    input logic win_under,
    input logic [$clog2(BR_THRESH+1)-1:0] br_cnt,
    input logic [$clog2(HOLD_WINDOWS+1)-1:0] hold_cnt
);

    localparam int BW = $clog2(BR_THRESH + 1);
    localparam int HW = $clog2(HOLD_WINDOWS + 1);

    // R8: a stall forces ultra at the next edge.
    p_stall_ultra_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (mode == 2'b11));

    // R7: pre-stall without stall gives aggressive.
    p_prestall_aggr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_stall && !stall) |=> (mode == 2'b10));

    // R6: with no flag raised, the phase bit gives light.
    p_phase_light_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_stall && !stall && high_ipb) |=> (mode == 2'b01));

    // R10: with nothing active, the mode is basic.
    p_idle_basic_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_stall && !stall && !high_ipb) |=> (mode == 2'b00));

    // R5: an under-threshold window reloads the full hold.
    p_reload_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_under |=> (hold_cnt == HW'(HOLD_WINDOWS)));

    // R4: the hold counter never exceeds its load value.
    p_hold_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= HW'(HOLD_WINDOWS));

    // R3: the phase bit rises only after a window boundary.
    p_rise_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(high_ipb) |-> $past(win_end));

    // R9: the branch count stays within its saturation limit.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        br_cnt <= BW'(BR_THRESH));

    // R2: the under flag is only raised at a window boundary.
    p_under_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_under |-> win_end);

endmodule

bind bps_sleep_ctrl bps_sleep_chk #(
    .BR_THRESH    (BR_THRESH),
    .HOLD_WINDOWS (HOLD_WINDOWS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pre_stall (pre_stall),
    .stall     (stall),
    .mode      (mode),
    .high_ipb  (high_ipb),
    .win_end   (win_end),
    .win_under (win_under),
    .br_cnt    (br_cnt),
    .hold_cnt  (hold_cnt)
);

// File: tb/tb_bps_sleep_ctrl.sv
// Directed bench for bps_sleep_ctrl. Inputs change and outputs are sampled on
// the falling clock edge.
module tb_bps_sleep_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 512;
    localparam int THR  = 24;
    localparam int HOLD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       br_fetch = 1'b0;
    logic       pre_stall = 1'b0;
    logic       stall = 1'b0;
    logic [1:0] mode;
    logic       high_ipb;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bps_sleep_ctrl #(
        .WINDOW_CYCLES (WIN),
        .BR_THRESH     (THR),
        .HOLD_WINDOWS  (HOLD)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_fetch  (br_fetch),
        .pre_stall (pre_stall),
        .stall     (stall),
        .mode      (mode),
        .high_ipb  (high_ipb)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Holds reset for three edges, then releases it at a falling edge.
    task automatic do_reset();
        rst_n = 1'b0; br_fetch = 1'b0; pre_stall = 1'b0; stall = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One whole window with n strobes at its start; ends at the falling edge
    // just after the window's last rising edge.
    task automatic run_window(input int n);
        for (int i = 0; i < WIN; i++) begin
            br_fetch = (i < n);
            @(negedge clk);
        end
        br_fetch = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pre_stall = 1'b1; stall = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 mode", mode, 2'b00);
        check("R1 high_ipb", {1'b0, high_ipb}, 2'b00);
        do_reset();
    endtask

    task automatic t_threshold();
        do_reset();
        run_window(THR);
        check("R3 exactly threshold", {1'b0, high_ipb}, 2'b00);
        do_reset();
        run_window(THR - 1);
        check("R3 one below threshold", {1'b0, high_ipb}, 2'b01);
        check("R6 mode lags phase bit", mode, 2'b00);
    endtask

    task automatic t_window_align();
        // Empty first window: nothing is declared until its last edge.
        do_reset();
        for (int i = 0; i < WIN - 1; i++) @(negedge clk);
        check("R2 before boundary", {1'b0, high_ipb}, 2'b00);
        @(negedge clk);
        check("R2 at boundary", {1'b0, high_ipb}, 2'b01);
        // Count restart: 30 then 10 must give under in the second window.
        do_reset();
        run_window(30);
        check("R2 first window above", {1'b0, high_ipb}, 2'b00);
        run_window(10);
        check("R2 count restarts", {1'b0, high_ipb}, 2'b01);
    endtask

    task automatic t_saturate();
        do_reset();
        run_window(WIN);
        check("R9 full window", {1'b0, high_ipb}, 2'b00);
        run_window(THR + 300);
        check("R9 large count", {1'b0, high_ipb}, 2'b00);
    endtask

    task automatic t_hold();
        do_reset();
        run_window(0);
        check("R4 declared", {1'b0, high_ipb}, 2'b01);
        for (int w = 1; w < HOLD; w++) begin
            run_window(WIN);
            if (w == 1) check("R6 light mode", mode, 2'b01);
        end
        check("R4 held through window 19", {1'b0, high_ipb}, 2'b01);
        run_window(WIN);
        check("R4 cleared after 20", {1'b0, high_ipb}, 2'b00);
        check("R4 mode lag", mode, 2'b01);
        @(negedge clk);
        check("R10 back to basic", mode, 2'b00);
    endtask

    task automatic t_reload();
        do_reset();
        run_window(0);
        run_window(0);
        for (int w = 1; w < HOLD; w++) run_window(WIN);
        check("R5 still held after reload", {1'b0, high_ipb}, 2'b01);
        run_window(WIN);
        check("R5 clears 20 after reload", {1'b0, high_ipb}, 2'b00);
    endtask

    task automatic t_priority();
        do_reset();
        @(negedge clk);
        check("R10 idle", mode, 2'b00);
        pre_stall = 1'b1;
        @(negedge clk);
        check("R7 pre-stall", mode, 2'b10);
        stall = 1'b1;
        @(negedge clk);
        check("R8 stall over pre-stall", mode, 2'b11);
        pre_stall = 1'b0; stall = 1'b0;
        @(negedge clk);
        check("R10 flags dropped", mode, 2'b00);
        // Now inside a high-IPB phase.
        do_reset();
        run_window(0);
        @(negedge clk);
        check("R6 light", mode, 2'b01);
        stall = 1'b1;
        @(negedge clk);
        check("R8 stall over phase", mode, 2'b11);
        stall = 1'b0; pre_stall = 1'b1;
        @(negedge clk);
        check("R7 pre-stall over phase", mode, 2'b10);
        pre_stall = 1'b0;
        @(negedge clk);
        check("R6 back to light", mode, 2'b01);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_threshold();
        t_window_align();
        t_saturate();
        t_priority();
        t_hold();
        t_reload();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule